// File: doc/BRIEF.md
# Machine-Cycle Timer Channel with Wide and Reloading Modes

This block is one timer channel of a small controller. A free-running prescaler divides the oscillator clock into machine-cycle ticks, one tick every `DIV` clocks (12 by default). While the run input is high, each tick advances a count held in two bytes, a high byte and a low byte. A 2-bit mode input selects how the count behaves. In the wide modes the two bytes form a single 16-bit up-counter. In the reload mode only the low byte counts, and on wrap it is reloaded from the high byte, which then serves as the reload constant. The remaining mode code holds the count.

Each wrap raises an overflow flag, `irq_o`, which acts as the interrupt request. The flag stays up until the interrupt controller acknowledges this source. Each wrap also produces a one-clock pulse on `ovf_pulse_o`, which can drive a baud-rate generator. The host can write either count byte at any time, and both bytes are always visible on the outputs.

A small state machine tracks the flag. It has two states: FLAG_CLEAR and FLAG_PENDING. Any wrap moves it from FLAG_CLEAR to FLAG_PENDING. An acknowledge without a wrap in the same cycle moves it from FLAG_PENDING back to FLAG_CLEAR. If a wrap and an acknowledge arrive together, it stays in FLAG_PENDING.

Top module: `tmr_channel`

## Requirements
- R1: After reset the prescaler emits one tick every DIV clocks, and the first tick falls in the DIV-th clock after reset is released. A running channel changes its count only on a tick.
- R2: In mode 2'b01 the bytes form a 16-bit up-counter {hi,lo}. A tick at 16'hFFFF wraps it to 16'h0000 and counts as an overflow. When run is raised in a clock where no tick is due, a load of 16'hFE0C overflows 500 ticks later, which is 500*DIV clocks.
- R3: Mode 2'b00 behaves exactly like mode 2'b01 (16-bit up-count, wrap from 16'hFFFF to 16'h0000).
- R4: In mode 2'b10 only the low byte counts. A tick at lo=8'hFF loads lo from hi and counts as an overflow. The high byte never changes except by a host write.
- R5: In mode 2'b11 the count holds and no overflow occurs.
- R6: While run_i is low the count holds and no overflow occurs.
- R7: An overflow sets irq_o in the clock that follows the counting edge. irq_o then stays high until it is acknowledged.
- R8: ack_i high in a clock with no overflow clears irq_o for the next clock. If an overflow happens in the same clock as ack_i, the overflow wins and irq_o stays high.
- R9: ovf_pulse_o is high for exactly one clock per overflow, in the same clock that irq_o is set.
- R10: A host write to a count byte takes priority over a tick. In any clock with wr_lo_i or wr_hi_i high, the count does not advance and no overflow occurs. The written byte shows on its output in the next clock, and the other byte keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Count mode: 00/01 16-bit, 10 8-bit reload, 11 hold |
| run_i | input | 1 | Count enable |
| wr_lo_i | input | 1 | Write wr_data_i into the low byte |
| wr_hi_i | input | 1 | Write wr_data_i into the high byte |
| wr_data_i | input | 8 | Host write data |
| ack_i | input | 1 | Interrupt acknowledge for this source |
| cnt_lo_o | output | 8 | Low count byte |
| cnt_hi_o | output | 8 | High count byte |
| irq_o | output | 1 | Overflow flag / interrupt request |
| ovf_pulse_o | output | 1 | One-clock pulse per overflow |

## Verification
Prescaler phase is the internal state hardest to see. If the prescaler phase is wrong, the count moves in the wrong clock. A behavioural model compares against the count bytes in every clock, so such an error shows within one tick period, and the 500-tick interval check measures it in whole clocks. A flag that is stuck or lost shows on irq_o at the first overflow or acknowledge that follows. A lost reload shows in the low byte one clock after the wrap, and a wrongly disturbed high byte shows in the clock after the disturbance.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_W13     = 2'b00,
        MODE_W16     = 2'b01,
        MODE_RELOAD8 = 2'b10,
        MODE_HOLD    = 2'b11
    } tmr_mode_e;

    typedef enum logic {
        FLAG_CLEAR   = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;

    assign tick_o = (pre_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (tick_o) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R1
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/tmr_count.sv
module tmr_count
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         run_i,
    input  tmr_mode_e    mode_i,
    input  logic         wr_lo_i,
    input  logic         wr_hi_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] lo_o,
    output logic [W-1:0] hi_o,
    output logic         wrap_o
);
    localparam int CW = 2 * W;

    logic [W-1:0] lo_q, hi_q, lo_n, hi_n;
    logic [CW-1:0] wide_sum;
    logic step;

    assign step     = tick_i && run_i && !(wr_lo_i || wr_hi_i);
    assign wide_sum = {hi_q, lo_q} + CW'(1);

    always_comb begin
        lo_n   = lo_q;
        hi_n   = hi_q;
        wrap_o = 1'b0;
        if (step) begin
            unique case (mode_i)
                MODE_W13, MODE_W16: begin
                    {hi_n, lo_n} = wide_sum;
                    wrap_o       = &{hi_q, lo_q};
                end
                MODE_RELOAD8: begin
                    if (&lo_q) begin
                        lo_n   = hi_q;
                        wrap_o = 1'b1;
                    end else begin
                        lo_n = lo_q + 1'b1;
                    end
                end
                MODE_HOLD: begin
                    lo_n = lo_q;
                end
                default: begin
                    lo_n = lo_q;
                end
            endcase
        end
        if (wr_lo_i) lo_n = wr_data_i;
        if (wr_hi_i) hi_n = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end

    assign lo_o = lo_q;
    assign hi_o = hi_q;

    // R4
    reload_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_RELOAD8 && !wr_hi_i) |=> $stable(hi_q));

    // R5
    reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_HOLD && !wr_lo_i && !wr_hi_i) |=> $stable({hi_q, lo_q}));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wr_lo_i && !wr_hi_i) |=> $stable({hi_q, lo_q}));

    // R10
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo_i && !wr_hi_i) |=> (lo_q == $past(wr_data_i)) && $stable(hi_q));

endmodule

// File: rtl/tmr_flag.sv
module tmr_flag
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_i,
    input  logic ack_i,
    output logic irq_o,
    output logic pulse_o
);
    flag_state_e state_q, state_n;
    logic        pulse_q;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            FLAG_CLEAR:   if (wrap_i)           state_n = FLAG_PENDING;
            FLAG_PENDING: if (ack_i && !wrap_i) state_n = FLAG_CLEAR;
            default:                            state_n = FLAG_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_CLEAR;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_n;
            pulse_q <= wrap_i;
        end
    end

    always_comb begin
        irq_o   = (state_q == FLAG_PENDING);
        pulse_o = pulse_q;
    end

    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);

    // R7
    pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> (state_q == FLAG_PENDING));

    // R7
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLAG_PENDING && !ack_i) |=> (state_q == FLAG_PENDING));

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !wrap_i) |=> (state_q == FLAG_CLEAR));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int DIV = 12,
    parameter int W   = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode_i,
    input  logic         run_i,
    input  logic         wr_lo_i,
    input  logic         wr_hi_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         ack_i,
    output logic [W-1:0] cnt_lo_o,
    output logic [W-1:0] cnt_hi_o,
    output logic         irq_o,
    output logic         ovf_pulse_o
);
    logic      tick;
    logic      wrap;
    tmr_mode_e mode;

    assign mode = tmr_mode_e'(mode_i);

    tmr_prescale #(.DIV(DIV)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    tmr_count #(.W(W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .run_i     (run_i),
        .mode_i    (mode),
        .wr_lo_i   (wr_lo_i),
        .wr_hi_i   (wr_hi_i),
        .wr_data_i (wr_data_i),
        .lo_o      (cnt_lo_o),
        .hi_o      (cnt_hi_o),
        .wrap_o    (wrap)
    );

    tmr_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap_i  (wrap),
        .ack_i   (ack_i),
        .irq_o   (irq_o),
        .pulse_o (ovf_pulse_o)
    );

    // R2
    wide_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_pulse_o && $past(mode_i[1] == 1'b0)) |-> ({cnt_hi_o, cnt_lo_o} == '0));

endmodule

// File: tb/tb_tmr_channel.sv
module tb_tmr_channel;
    localparam int DIV = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'b01;
    logic       run_i = 1'b0;
    logic       wr_lo_i = 1'b0;
    logic       wr_hi_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       ack_i = 1'b0;
    logic [7:0] cnt_lo_o, cnt_hi_o;
    logic       irq_o, ovf_pulse_o;

    tmr_channel #(.DIV(DIV), .W(8)) dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .run_i(run_i),
        .wr_lo_i(wr_lo_i), .wr_hi_i(wr_hi_i), .wr_data_i(wr_data_i),
        .ack_i(ack_i), .cnt_lo_o(cnt_lo_o), .cnt_hi_o(cnt_hi_o),
        .irq_o(irq_o), .ovf_pulse_o(ovf_pulse_o)
    );

    always #5 clk = ~clk;

    int vectors = 0;
    int fails = 0;
    bit armed = 0;
    bit done = 0;
    string cur_req = "R1";

    // behavioural reference
    int m_p = 0, m_lo = 0, m_hi = 0, m_flag = 0, m_pulse = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_p = 0; m_lo = 0; m_hi = 0; m_flag = 0; m_pulse = 0;
        end else begin
            bit tk, wrp;
            int c;
            tk = (m_p == DIV - 1);
            m_p = tk ? 0 : m_p + 1;
            wrp = 0;
            if (tk && run_i && !wr_lo_i && !wr_hi_i) begin
                if (mode_i == 2'b00 || mode_i == 2'b01) begin
                    c = m_hi * 256 + m_lo;
                    if (c == 65535) begin c = 0; wrp = 1; end else c = c + 1;
                    m_hi = c / 256; m_lo = c % 256;
                end else if (mode_i == 2'b10) begin
                    if (m_lo == 255) begin m_lo = m_hi; wrp = 1; end
                    else m_lo = m_lo + 1;
                end
            end
            if (wr_lo_i) m_lo = int'(wr_data_i);
            if (wr_hi_i) m_hi = int'(wr_data_i);
            m_pulse = wrp ? 1 : 0;
            if (wrp) m_flag = 1; else if (ack_i) m_flag = 0;
        end
        armed = 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !done) begin
            chk(int'(cnt_lo_o) == m_lo, cur_req, int'(cnt_lo_o), m_lo);
            chk(int'(cnt_hi_o) == m_hi, cur_req, int'(cnt_hi_o), m_hi);
            chk(int'(irq_o) == m_flag, cur_req, int'(irq_o), m_flag);
            chk(int'(ovf_pulse_o) == m_pulse, cur_req, int'(ovf_pulse_o), m_pulse);
        end
    end

    task automatic write16(input logic [15:0] v);
        @(negedge clk);
        wr_lo_i = 1'b1; wr_hi_i = 1'b1; wr_data_i = v[7:0];
        @(negedge clk);
        wr_hi_i = 1'b0; wr_data_i = v[7:0];
        wr_lo_i = 1'b0; wr_hi_i = 1'b1; wr_data_i = v[15:8];
        @(negedge clk);
        wr_hi_i = 1'b0;
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ovf_pulse_o && n < 20000);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int n;
        logic [7:0] hold_lo, hold_hi;
        repeat (3) @(negedge clk);
        cur_req = "R7";
        chk(cnt_lo_o == 8'h00 && cnt_hi_o == 8'h00, "R7 reset count", int'({cnt_hi_o, cnt_lo_o}), 0);
        chk(irq_o == 1'b0 && ovf_pulse_o == 1'b0, "R7 reset flag", int'(irq_o), 0);
        rst_n = 1'b1;

        // R1: first tick in the DIV-th clock after release
        cur_req = "R1";
        mode_i = 2'b01; run_i = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (cnt_lo_o == 8'h00 && n < 100);
        chk(n == DIV, "R1 first tick clocks", n, DIV);
        run_i = 1'b0;

        // R2: 0xFE0C -> overflow after 500 ticks
        cur_req = "R2";
        write16(16'hFE0C);
        while (m_p != 0) @(negedge clk);
        run_i = 1'b1;
        wait_pulse(n);
        chk(n == 500 * DIV, "R2 interval clocks", n, 500 * DIV);
        chk({cnt_hi_o, cnt_lo_o} == 16'h0000, "R2 wrap value", int'({cnt_hi_o, cnt_lo_o}), 0);
        chk(irq_o == 1'b1, "R9 pulse with flag", int'(irq_o), 1);
        @(negedge clk);
        chk(ovf_pulse_o == 1'b0, "R9 pulse width", int'(ovf_pulse_o), 0);

        // R7 / R8: flag stays, then acknowledge clears
        cur_req = "R8";
        repeat (30) @(negedge clk);
        chk(irq_o == 1'b1, "R7 flag held", int'(irq_o), 1);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        chk(irq_o == 1'b0, "R8 ack clears", int'(irq_o), 0);

        // R6: run low holds
        cur_req = "R6";
        run_i = 1'b0;
        hold_lo = cnt_lo_o; hold_hi = cnt_hi_o;
        repeat (5 * DIV) @(negedge clk);
        chk(cnt_lo_o == hold_lo && cnt_hi_o == hold_hi, "R6 idle hold",
            int'({cnt_hi_o, cnt_lo_o}), int'({hold_hi, hold_lo}));

        // R3: mode 00 wraps as 16-bit
        cur_req = "R3";
        mode_i = 2'b00;
        write16(16'hFFFD);
        run_i = 1'b1;
        wait_pulse(n);
        chk({cnt_hi_o, cnt_lo_o} == 16'h0000 && irq_o, "R3 wide wrap",
            int'({cnt_hi_o, cnt_lo_o}), 0);
        run_i = 1'b0;

        // R4: reload mode
        cur_req = "R4";
        mode_i = 2'b10;
        write16(16'hF0FC);
        run_i = 1'b1;
        wait_pulse(n);
        chk(cnt_lo_o == 8'hF0, "R4 reload lo", int'(cnt_lo_o), 8'hF0);
        chk(cnt_hi_o == 8'hF0, "R4 hi kept", int'(cnt_hi_o), 8'hF0);
        repeat (20 * DIV) @(negedge clk);
        chk(cnt_hi_o == 8'hF0, "R4 hi kept later", int'(cnt_hi_o), 8'hF0);

        // R8: overflow coincident with acknowledge wins
        cur_req = "R8";
        write16(16'hFEFE);
        ack_i = 1'b1;
        wait_pulse(n);
        chk(irq_o == 1'b1, "R8 set wins", int'(irq_o), 1);
        @(negedge clk);
        chk(irq_o == 1'b0, "R8 ack after set", int'(irq_o), 0);
        ack_i = 1'b0;

        // R5: reserved mode holds
        cur_req = "R5";
        mode_i = 2'b11;
        hold_lo = cnt_lo_o; hold_hi = cnt_hi_o;
        repeat (40 * DIV) @(negedge clk);
        chk(cnt_lo_o == hold_lo && cnt_hi_o == hold_hi && !ovf_pulse_o, "R5 reserved hold",
            int'({cnt_hi_o, cnt_lo_o}), int'({hold_hi, hold_lo}));

        // R10: write in a tick clock wins, no carry
        cur_req = "R10";
        mode_i = 2'b01;
        write16(16'h12FF);
        while (m_p != DIV - 1) @(negedge clk);
        wr_lo_i = 1'b1; wr_data_i = 8'h55;
        @(negedge clk);
        wr_lo_i = 1'b0;
        chk(cnt_lo_o == 8'h55, "R10 write wins lo", int'(cnt_lo_o), 8'h55);
        chk(cnt_hi_o == 8'h12, "R10 no carry hi", int'(cnt_hi_o), 8'h12);

        // R10: write at a would-be wrap suppresses overflow
        write16(16'hFFFF);
        ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;
        while (m_p != DIV - 1) @(negedge clk);
        wr_hi_i = 1'b1; wr_data_i = 8'hFF;
        @(negedge clk);
        wr_hi_i = 1'b0;
        chk(ovf_pulse_o == 1'b0 && irq_o == 1'b0, "R10 no overflow on write",
            int'(ovf_pulse_o), 0);
        chk({cnt_hi_o, cnt_lo_o} == 16'hFFFF, "R10 count kept",
            int'({cnt_hi_o, cnt_lo_o}), 16'hFFFF);
        run_i = 1'b0;

        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule